// File: doc/BRIEF.md
# Dual-Loop Synthesizer Power-Down Sequencer

This block decides, for each loop of a dual frequency synthesizer, when the loop leaves normal operation and when it comes back. The configuration registers supply each loop's power-down request bit, a shared mode bit and each loop's counter-reset bit. Each loop also reports the end of its charge-pump pulse. From these inputs the block drives per-loop enables for the feedback (N) divider and the reference (R) counter, a tri-state control for the charge pump and phase comparator, and a de-bias control that puts the loop's RF inputs into high impedance. It also drives one shared pin-release control, which puts a common output pin into high impedance.

In asynchronous mode a request takes effect at the next clock edge. In synchronous mode the request waits in a per-loop pending state and takes effect only once that loop's charge-pump pulse has ended. Every output is registered, so each one changes exactly one clock edge after the inputs that cause it. Loop 0 is the RF loop and loop 1 is the IF loop.

Top module: `pll_pd_seq`

## Requirements
- R1: With `pd_sync` = 0, a high `pd_req[i]` sampled at an edge makes, after that edge, `n_en[i]` = 0, `r_en[i]` = 0, `cp_tristate[i]` = 1 and `in_hiz[i]` = 1.
- R2: With `pd_sync` = 1, a loop that is up and has `pd_req[i]` high stays up (enables 1, `cp_tristate[i]` = 0) for as long as `cp_pulse_end[i]` is not sampled high.
- R3: With `pd_sync` = 1 and `pd_req[i]` high, a high `cp_pulse_end[i]` sampled at an edge powers the loop down after that edge. This includes the edge at which the request is first seen.
- R4: A synchronous request that is still pending is dropped when `pd_req[i]` is sampled low. A later `cp_pulse_end[i]` then has no effect, and a new request waits for a new pulse end.
- R5: `pd_req[i]` sampled low returns `cp_tristate[i]` and `in_hiz[i]` to 0 after that edge in either mode. The enables also return to 1 unless `cnt_rst[i]` is high.
- R6: `pin_hiz` is 1 after an edge at which every bit of `pd_req` was high, and 0 otherwise. It does not depend on the mode or on the pulse events.
- R7: A high `cnt_rst[i]` sampled at an edge drives `n_en[i]` and `r_en[i]` to 0 after that edge. It does not change `cp_tristate[i]`.
- R8: `n_en[i]` and `r_en[i]` are equal in every cycle, so both counters restart in the same cycle after power-up or counter-reset release.
- R9: While `rst_n` is low, and directly after it rises, all enables are 1, and `cp_tristate`, `in_hiz` and `pin_hiz` are 0.
- R10: A loop that is down stays down while `pd_req[i]` remains high, whatever `pd_sync` and `cp_pulse_end[i]` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | NUM_LOOPS | Latched power-down request per loop (bit 0 RF, bit 1 IF) |
| pd_sync | input | 1 | 1 = enter power down after pulse end, 0 = enter at once |
| cnt_rst | input | NUM_LOOPS | Counter-reset bit per loop, holds N and R counters |
| cp_pulse_end | input | NUM_LOOPS | Per-loop event marking the end of a charge-pump pulse |
| n_en | output | NUM_LOOPS | N divider enable per loop |
| r_en | output | NUM_LOOPS | R counter enable per loop |
| cp_tristate | output | NUM_LOOPS | Charge pump and phase comparator tri-state per loop |
| in_hiz | output | NUM_LOOPS | RF input de-bias (high impedance) per loop |
| pin_hiz | output | 1 | Shared output pin high-impedance control |

## Verification
The bench builds the block with its defaults: two loops, with the synchronous variant generated. This configuration exercises the pending state, cancellation of a pending request, and entry on a pulse end that arrives in the same cycle as the request. Because both loops exist, the bench can drive one loop down while the other is waiting or up, and it can check that the shared pin is released only when both requests are present. With the synchronous variant generated, switching the mode bit between vectors shows that a loop which is already down is no longer affected by the mode.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;
   typedef enum logic [1:0] {
      LP_UP   = 2'd0,
      LP_WAIT = 2'd1,
      LP_DOWN = 2'd2
   } lp_state_e;
endpackage

// File: rtl/pll_pd_loop_fsm.sv
module pll_pd_loop_fsm
   import pll_pd_pkg::*;
#(
   parameter bit SYNC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic pd_sync,
   input  logic pulse_end,
   output logic down_nxt
);
   lp_state_e state_q, state_d;
   logic      sync_eff;

   generate
      if (SYNC_EN) begin : g_sync
         assign sync_eff = pd_sync;
      end else begin : g_async_only
         assign sync_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      if (!pd_req) begin
         state_d = LP_UP;
      end else if (state_q != LP_DOWN) begin
         if (!sync_eff || pulse_end) state_d = LP_DOWN;
         else                        state_d = LP_WAIT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LP_UP;
      else        state_q <= state_d;
   end

   assign down_nxt = (state_d == LP_DOWN);

   // R4: the pending state exists only while a request was present
   a_r4_wait_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_WAIT) |-> $past(pd_req));
   // R10: a down loop leaves only when its request is dropped
   a_r10_hold_down: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LP_DOWN && pd_req) |=> (state_q == LP_DOWN));
endmodule

// File: rtl/pll_pd_gate.sv
module pll_pd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic down_nxt,
   input  logic cnt_rst,
   output logic n_en,
   output logic r_en,
   output logic cp_tri,
   output logic in_hiz
);
   logic run_nxt;
   assign run_nxt = !down_nxt && !cnt_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) n_en <= 1'b1;
      else        n_en <= run_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_en <= 1'b1;
      else        r_en <= run_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cp_tri <= 1'b0;
         in_hiz <= 1'b0;
      end else begin
         cp_tri <= down_nxt;
         in_hiz <= down_nxt;
      end
   end

   // R8: both counters of a loop run or stop together
   a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      n_en == r_en);
   // R7: a counter reset stops both counters
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |=> !n_en);
endmodule

// File: rtl/pll_pd_pin.sv
module pll_pd_pin #(
   parameter int NUM_LOOPS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] pd_req,
   output logic                 pin_hiz
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_hiz <= 1'b0;
      else        pin_hiz <= &pd_req;
   end

   // R6: pin released only with every request present
   a_r6_pin_all: assert property (@(posedge clk) disable iff (!rst_n)
      (&pd_req) |=> pin_hiz);
   a_r6_pin_any_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(&pd_req) |=> !pin_hiz);
endmodule

// File: rtl/pll_pd_seq.sv
module pll_pd_seq #(
   parameter int NUM_LOOPS = 2,
   parameter bit SYNC_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOOPS-1:0] pd_req,
   input  logic                 pd_sync,
   input  logic [NUM_LOOPS-1:0] cnt_rst,
   input  logic [NUM_LOOPS-1:0] cp_pulse_end,
   output logic [NUM_LOOPS-1:0] n_en,
   output logic [NUM_LOOPS-1:0] r_en,
   output logic [NUM_LOOPS-1:0] cp_tristate,
   output logic [NUM_LOOPS-1:0] in_hiz,
   output logic                 pin_hiz
);
   localparam int LAST_LOOP = NUM_LOOPS - 1;

   generate
      if (NUM_LOOPS < 1 || NUM_LOOPS > 8) begin : g_bad_loops
         $error("pll_pd_seq: NUM_LOOPS must lie in 1..8");
      end
   endgenerate

   generate
      for (genvar i = 0; i <= LAST_LOOP; i++) begin : g_loop
         logic down_nxt;

         pll_pd_loop_fsm #(.SYNC_EN(SYNC_EN)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .pd_req   (pd_req[i]),
            .pd_sync  (pd_sync),
            .pulse_end(cp_pulse_end[i]),
            .down_nxt (down_nxt)
         );

         pll_pd_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .down_nxt(down_nxt),
            .cnt_rst (cnt_rst[i]),
            .n_en    (n_en[i]),
            .r_en    (r_en[i]),
            .cp_tri  (cp_tristate[i]),
            .in_hiz  (in_hiz[i])
         );

         // R1: immediate entry
         a_r1_async_down: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_req[i] && (!pd_sync || !SYNC_EN)) |=> (cp_tristate[i] && in_hiz[i] && !n_en[i]));
         // R2: waiting loop stays up without a pulse end
         a_r2_wait_up: assert property (@(posedge clk) disable iff (!rst_n)
            (SYNC_EN && pd_req[i] && pd_sync && !cp_pulse_end[i] && !cp_tristate[i]) |=> !cp_tristate[i]);
         // R3: pulse end completes a synchronous entry
         a_r3_sync_down: assert property (@(posedge clk) disable iff (!rst_n)
            (pd_req[i] && cp_pulse_end[i]) |=> cp_tristate[i]);
         // R5: release in either mode
         a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
            !pd_req[i] |=> (!cp_tristate[i] && !in_hiz[i]));
      end
   endgenerate

   pll_pd_pin #(.NUM_LOOPS(NUM_LOOPS)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_req (pd_req),
      .pin_hiz(pin_hiz)
   );
endmodule

// File: tb/tb_pll_pd_seq.sv
module tb_pll_pd_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 21;
   localparam int WATCHDOG_CYCLES = 5000;

   // {tag[4], req[2], sync, rst[2], pulse_end[2], exp_en[2], exp_cp[2], exp_pin}
   localparam logic [15:0] VEC [NV] = '{
      {4'd1,  2'b01, 1'b0, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0}, // R1 RF async down
      {4'd5,  2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R5 release
      {4'd2,  2'b10, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R2 IF waits
      {4'd2,  2'b10, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R2 still waits
      {4'd3,  2'b10, 1'b1, 2'b00, 2'b10, 2'b01, 2'b10, 1'b0}, // R3 pulse end
      {4'd10, 2'b10, 1'b1, 2'b00, 2'b00, 2'b01, 2'b10, 1'b0}, // R10 stays down
      {4'd6,  2'b11, 1'b0, 2'b00, 2'b00, 2'b00, 2'b11, 1'b1}, // R6 both down
      {4'd5,  2'b00, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R5 release sync
      {4'd2,  2'b01, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R2 RF pending
      {4'd4,  2'b00, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R4 cancel
      {4'd4,  2'b00, 1'b1, 2'b00, 2'b01, 2'b11, 2'b00, 1'b0}, // R4 stray pulse end
      {4'd4,  2'b01, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R4 new request waits
      {4'd3,  2'b01, 1'b1, 2'b00, 2'b01, 2'b10, 2'b01, 1'b0}, // R3 pulse end
      {4'd10, 2'b01, 1'b0, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0}, // R10 mode flip
      {4'd7,  2'b00, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0}, // R7 both held
      {4'd8,  2'b00, 1'b0, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R8 restart
      {4'd6,  2'b11, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b1}, // R6 pin while waiting
      {4'd3,  2'b11, 1'b1, 2'b00, 2'b11, 2'b00, 2'b11, 1'b1}, // R3 both pulse end
      {4'd6,  2'b01, 1'b1, 2'b00, 2'b00, 2'b10, 2'b01, 1'b0}, // R6 IF released
      {4'd5,  2'b00, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 1'b0}, // R5 all up
      {4'd7,  2'b00, 1'b0, 2'b01, 2'b00, 2'b10, 2'b00, 1'b0}  // R7 RF only held
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pd_req = '0;
   logic       pd_sync = 1'b0;
   logic [1:0] cnt_rst = '0;
   logic [1:0] cp_pulse_end = '0;
   logic [1:0] n_en, r_en, cp_tristate, in_hiz;
   logic       pin_hiz;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_pd_seq dut (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_sync(pd_sync),
      .cnt_rst(cnt_rst), .cp_pulse_end(cp_pulse_end),
      .n_en(n_en), .r_en(r_en), .cp_tristate(cp_tristate),
      .in_hiz(in_hiz), .pin_hiz(pin_hiz)
   );

   task automatic check(input string tag, input logic [1:0] en_e,
                        input logic [1:0] cp_e, input logic pin_e);
      checks++;
      if (n_en !== en_e || r_en !== en_e || cp_tristate !== cp_e ||
          in_hiz !== cp_e || pin_hiz !== pin_e) begin
         errors++;
         $display("FAIL %s: n_en=%b r_en=%b cp=%b hiz=%b pin=%b expected en=%b cp=%b hiz=%b pin=%b",
                  tag, n_en, r_en, cp_tristate, in_hiz, pin_hiz, en_e, cp_e, cp_e, pin_e);
      end
   endtask

   task automatic step(input logic [1:0] rq, input logic sy,
                       input logic [1:0] cr, input logic [1:0] pe);
      pd_req = rq; pd_sync = sy; cnt_rst = cr; cp_pulse_end = pe;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 in reset", 2'b11, 2'b00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 after reset", 2'b11, 2'b00, 1'b0);

      for (int v = 0; v < NV; v++) begin
         step(VEC[v][11:10], VEC[v][9], VEC[v][8:7], VEC[v][6:5]);
         check($sformatf("R%0d vector %0d", VEC[v][15:12], v),
               VEC[v][4:3], VEC[v][2:1], VEC[v][0]);
      end

      // R3 pulse end in the same cycle as the first request, IF loop
      step(2'b00, 1'b1, 2'b00, 2'b00);
      step(2'b10, 1'b1, 2'b00, 2'b10);
      check("R3 same-cycle pulse end", 2'b01, 2'b10, 1'b0);
      // R7 counter reset on a down loop leaves tri-state unchanged
      step(2'b10, 1'b1, 2'b10, 2'b00);
      check("R7 reset on down loop", 2'b01, 2'b10, 1'b0);
      // R5 release while reset still held: outputs released, enables held
      step(2'b00, 1'b1, 2'b10, 2'b00);
      check("R5 release under counter reset", 2'b01, 2'b00, 1'b0);
      step(2'b00, 1'b1, 2'b00, 2'b00);
      check("R8 joint restart", 2'b11, 2'b00, 1'b0);

      // R9 reset in the middle of power down
      step(2'b11, 1'b0, 2'b00, 2'b00);
      check("R1 both async", 2'b00, 2'b11, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R9 reset asserted while down", 2'b11, 2'b00, 1'b0);
      pd_req = 2'b00;
      @(negedge clk);
      rst_n = 1'b1;
      step(2'b00, 1'b0, 2'b00, 2'b00);
      check("R9 idle after reset", 2'b11, 2'b00, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule